// File: doc/BRIEF.md
# Operand Address Generator

This block turns the location fields of one virtual-machine instruction into operand addresses. It takes the 3-bit location codes for the source operands A and B and for the destination operand C. It also takes the 32-bit values of the registers those operands name, plus two 32-bit masks: the read mask for A and the immediate used as the write mask for C. Register selection and register storage belong to the surrounding logic, so only the chosen values arrive here.

For A, the block reports whether the read goes to the large dataset or to the scratchpad, and it produces the address. For B, it reports whether the operand is the register or the immediate. For C, it reports whether the result goes to a register or to the scratchpad, and it produces the scratchpad byte address.

Each address is the register value XORed with its mask and then cut to a width that the location code chooses. Scratchpad addresses are then multiplied by eight so that every access is 8-byte aligned. Dataset addresses are not scaled. All results pass through one register stage, and a valid flag goes with them.

Top module: `opaddr_gen`

## Requirements
- R1: After reset every output is zero. `outValid` is high exactly in the cycle after a cycle in which `inValid` was high.
- R2: `locA` codes 0 to 3 give `aFromScratch`=0, and `aAddr` equals `regAVal ^ maskA` with all 32 bits kept and no scaling.
- R3: `locA` code 4 gives `aFromScratch`=1, and `aAddr` equals `((regAVal ^ maskA) & 0x7FFF) << 3`.
- R4: `locA` codes 5 to 7 give `aFromScratch`=1, and `aAddr` equals `((regAVal ^ maskA) & 0x7FF) << 3`.
- R5: `locB` codes 0 to 5 give `bFromImm`=0, and codes 6 and 7 give `bFromImm`=1.
- R6: `locC` code 0 gives `cToScratch`=1, and `cAddr` equals `((imm1 ^ regCVal) & 0x7FFF) << 3`.
- R7: `locC` codes 1 to 3 give `cToScratch`=1, and `cAddr` equals `((imm1 ^ regCVal) & 0x7FF) << 3`.
- R8: `locC` codes 4 to 7 give `cToScratch`=0 and `cAddr`=0.
- R9: While `inValid` is low, `aAddr`, `cAddr`, `aFromScratch`, `bFromImm` and `cToScratch` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | The instruction fields on the inputs are valid |
| locA | input | 3 | Location code of operand A |
| locB | input | 3 | Location code of operand B |
| locC | input | 3 | Location code of operand C |
| regAVal | input | 32 | Low 32 bits of the register named for A |
| regCVal | input | 32 | Low 32 bits of the register named for C |
| maskA | input | 32 | XOR mask for the A read address |
| imm1 | input | 32 | Immediate, used as the XOR mask for the C address |
| outValid | output | 1 | The outputs hold a new result |
| aFromScratch | output | 1 | 1: A is read from the scratchpad; 0: A is read from the dataset |
| aAddr | output | 32 | A address (dataset word address, or scratchpad byte address) |
| bFromImm | output | 1 | 1: B is the immediate; 0: B is the register |
| cToScratch | output | 1 | 1: C is written to the scratchpad; 0: C is written to a register |
| cAddr | output | 32 | C scratchpad byte address; zero for a register write |

## Verification
The bench walks all eight codes of each location field. The register values have ones in bits 11 to 17 and in bits 29 to 31, so a 15-bit cut, an 11-bit cut and a full 32-bit address each give a different result. The masks are chosen so that they flip some of those bits, which shows whether the XOR is applied before the truncation or after it. Vectors with low bits set would catch a scratchpad address that is left unscaled or a dataset address that is scaled by mistake. Directed steps then cover the reset values, outputs holding while `inValid` is low, and masks that cancel the register value to zero.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
  localparam int DATA_W    = 32;
  localparam int WIDE_W    = 15;
  localparam int NARROW_W  = 11;
  localparam int SCALE_SH  = 3;
  localparam int LOC_W     = 3;

  typedef struct packed {
    logic aScratch;
    logic aWide;
    logic bImm;
    logic cScratch;
    logic cWide;
  } addr_ctrl_t;
endpackage

// File: rtl/opaddr_ctrl.sv
module opaddr_ctrl
  import opaddr_pkg::*;
#(
  parameter int LW = LOC_W
) (
  input  logic [LW-1:0] locA,
  input  logic [LW-1:0] locB,
  input  logic [LW-1:0] locC,
  output addr_ctrl_t    ctrl
);
  localparam logic [LW-1:0] A_WIDE_CODE  = LW'(4);
  localparam logic [LW-1:0] B_IMM_FIRST  = LW'(6);
  localparam logic [LW-1:0] C_WIDE_CODE  = LW'(0);
  localparam logic [LW-1:0] C_REG_FIRST  = LW'(4);

  always_comb begin
    ctrl.aScratch = locA[LW-1];
    ctrl.aWide    = (locA == A_WIDE_CODE);
    ctrl.bImm     = (locB >= B_IMM_FIRST);
    ctrl.cScratch = (locC < C_REG_FIRST);
    ctrl.cWide    = (locC == C_WIDE_CODE);
  end
endmodule

// File: rtl/opaddr_dp.sv
module opaddr_dp
  import opaddr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int WW = WIDE_W,
  parameter int NW = NARROW_W,
  parameter int SH = SCALE_SH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inValid,
  input  addr_ctrl_t    ctrl,
  input  logic [DW-1:0] regAVal,
  input  logic [DW-1:0] regCVal,
  input  logic [DW-1:0] maskA,
  input  logic [DW-1:0] imm1,
  output logic          outValid,
  output logic          aFromScratch,
  output logic [DW-1:0] aAddr,
  output logic          bFromImm,
  output logic          cToScratch,
  output logic [DW-1:0] cAddr
);
  localparam logic [DW-1:0] WIDE_MASK   = DW'((64'd1 << WW) - 64'd1);
  localparam logic [DW-1:0] NARROW_MASK = DW'((64'd1 << NW) - 64'd1);
  localparam logic [DW-1:0] SP_LIMIT    = DW'(64'd1 << (WW + SH));

  logic [DW-1:0] aMixed, cMixed, aNext, cNext;

  function automatic logic [DW-1:0] scratchAddr(input logic [DW-1:0] v, input logic wide);
    logic [DW-1:0] m;
    m = wide ? WIDE_MASK : NARROW_MASK;
    return (v & m) << SH;
  endfunction

  always_comb begin
    aMixed = regAVal ^ maskA;
    cMixed = imm1 ^ regCVal;
    aNext  = ctrl.aScratch ? scratchAddr(aMixed, ctrl.aWide) : aMixed;
    cNext  = ctrl.cScratch ? scratchAddr(cMixed, ctrl.cWide) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid     <= 1'b0;
      aFromScratch <= 1'b0;
      aAddr        <= '0;
      bFromImm     <= 1'b0;
      cToScratch   <= 1'b0;
      cAddr        <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        aFromScratch <= ctrl.aScratch;
        aAddr        <= aNext;
        bFromImm     <= ctrl.bImm;
        cToScratch   <= ctrl.cScratch;
        cAddr        <= cNext;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid); // R1
  AST_A_SP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    aFromScratch |-> (aAddr[SH-1:0] == '0 && aAddr < SP_LIMIT)); // R3
  AST_C_SP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    cToScratch |-> (cAddr[SH-1:0] == '0 && cAddr < SP_LIMIT)); // R6
  AST_C_REG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cToScratch |-> cAddr == '0); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!inValid && $past(rst_n)) |=> $stable(aAddr) && $stable(cAddr)); // R9
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
  import opaddr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [2:0]  locA,
  input  logic [2:0]  locB,
  input  logic [2:0]  locC,
  input  logic [31:0] regAVal,
  input  logic [31:0] regCVal,
  input  logic [31:0] maskA,
  input  logic [31:0] imm1,
  output logic        outValid,
  output logic        aFromScratch,
  output logic [31:0] aAddr,
  output logic        bFromImm,
  output logic        cToScratch,
  output logic [31:0] cAddr
);
  addr_ctrl_t ctrl;

  opaddr_ctrl #(.LW(LOC_W)) u_ctrl (
    .locA(locA), .locB(locB), .locC(locC), .ctrl(ctrl)
  );

  opaddr_dp #(.DW(DATA_W), .WW(WIDE_W), .NW(NARROW_W), .SH(SCALE_SH)) u_dp (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .ctrl(ctrl),
    .regAVal(regAVal), .regCVal(regCVal), .maskA(maskA), .imm1(imm1),
    .outValid(outValid), .aFromScratch(aFromScratch), .aAddr(aAddr),
    .bFromImm(bFromImm), .cToScratch(cToScratch), .cAddr(cAddr)
  );
endmodule

// File: tb/opaddr_gen_bench.sv
`timescale 1ns/1ps
module opaddr_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [2:0] locA = '0, locB = '0, locC = '0;
  logic [31:0] regAVal = '0, regCVal = '0, maskA = '0, imm1 = '0;
  logic outValid, aFromScratch, bFromImm, cToScratch;
  logic [31:0] aAddr, cAddr;
  int nTests = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  opaddr_gen u_opaddr_gen (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .locA(locA), .locB(locB), .locC(locC),
    .regAVal(regAVal), .regCVal(regCVal), .maskA(maskA), .imm1(imm1),
    .outValid(outValid), .aFromScratch(aFromScratch), .aAddr(aAddr),
    .bFromImm(bFromImm), .cToScratch(cToScratch), .cAddr(cAddr)
  );

  // stimulus: locA, locB, locC, regA, regC, maskA, imm1
  localparam int NVEC = 10;
  localparam logic [136:0] VEC [NVEC] = '{
    {3'd0, 3'd0, 3'd0, 32'hE003_F807, 32'h0003_F805, 32'h0001_0001, 32'h0000_1004},
    {3'd1, 3'd1, 3'd1, 32'hE003_F807, 32'h0003_F805, 32'h0001_0001, 32'h0000_1004},
    {3'd2, 3'd2, 3'd2, 32'h8002_A8F3, 32'hA5A5_5A5A, 32'h0000_0000, 32'hFFFF_FFFF},
    {3'd3, 3'd3, 3'd3, 32'h1234_5678, 32'h1357_9BDF, 32'h8765_4321, 32'h0246_8ACE},
    {3'd4, 3'd4, 3'd4, 32'hE003_F807, 32'h0003_F805, 32'h0001_0001, 32'h0000_1004},
    {3'd5, 3'd5, 3'd5, 32'hE003_F807, 32'h0003_F805, 32'h0001_0001, 32'h0000_1004},
    {3'd6, 3'd6, 3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
    {3'd7, 3'd7, 3'd7, 32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h0F0F_0F0F, 32'h3333_CCCC},
    {3'd4, 3'd6, 3'd0, 32'hFFFF_FFFF, 32'h0000_7FFF, 32'h0000_0000, 32'hFFFF_FFFF},
    {3'd0, 3'd7, 3'd4, 32'hFFFF_FFFF, 32'h1111_1111, 32'hFFFF_FFFF, 32'h2222_2222}
  };

  function automatic logic [31:0] expA(input logic [2:0] l, input logic [31:0] r, input logic [31:0] m);
    logic [31:0] v;
    v = r ^ m;
    if (l < 3'd4) return v;
    else if (l == 3'd4) return (v & 32'h7FFF) << 3;
    else return (v & 32'h7FF) << 3;
  endfunction

  function automatic logic [31:0] expC(input logic [2:0] l, input logic [31:0] r, input logic [31:0] m);
    logic [31:0] v;
    v = m ^ r;
    if (l == 3'd0) return (v & 32'h7FFF) << 3;
    else if (l < 3'd4) return (v & 32'h7FF) << 3;
    else return 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [136:0] v);
    {locA, locB, locC, regAVal, regCVal, maskA, imm1} = v;
    inValid = 1'b1;
  endtask

  initial begin
    #150000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset outValid", 32'(outValid), 32'd0);
    check("R1 reset aAddr", aAddr, 32'd0);
    check("R1 reset cAddr", cAddr, 32'd0);
    check("R1 reset flags", {29'd0, aFromScratch, bFromImm, cToScratch}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle outValid", 32'(outValid), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] la, lb, lc;
      logic [31:0] ra, rc, ma, im;
      {la, lb, lc, ra, rc, ma, im} = VEC[i];
      drive(VEC[i]);
      @(negedge clk);
      check("R1 outValid", 32'(outValid), 32'd1);
      check(la < 3'd4 ? "R2 aAddr" : (la == 3'd4 ? "R3 aAddr" : "R4 aAddr"), aAddr, expA(la, ra, ma));
      check("R2 R3 R4 aFromScratch", 32'(aFromScratch), 32'(la >= 3'd4));
      check("R5 bFromImm", 32'(bFromImm), 32'(lb >= 3'd6));
      check(lc == 3'd0 ? "R6 cAddr" : (lc < 3'd4 ? "R7 cAddr" : "R8 cAddr"), cAddr, expC(lc, rc, im));
      check("R6 R7 R8 cToScratch", 32'(cToScratch), 32'(lc < 3'd4));
    end

    // R9: hold while idle, with new fields on the inputs
    inValid = 1'b0;
    locA = 3'd0; locB = 3'd0; locC = 3'd1;
    regAVal = 32'h1234_5678; regCVal = 32'h0000_00FF;
    @(negedge clk);
    check("R1 outValid drops", 32'(outValid), 32'd0);
    check("R9 aAddr hold", aAddr, expA(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF));
    check("R9 cAddr hold", cAddr, 32'd0);
    check("R9 flags hold", {29'd0, aFromScratch, bFromImm, cToScratch}, 32'b010);
    @(negedge clk);
    check("R9 aAddr hold 2", aAddr, 32'd0);

    // R3: mask cancels register, all-zero scratch address
    drive({3'd4, 3'd0, 3'd0, 32'hABCD_1234, 32'h5555_5555, 32'hABCD_1234, 32'h5555_5555});
    @(negedge clk);
    check("R3 zero aAddr", aAddr, 32'd0);
    check("R6 zero cAddr", cAddr, 32'd0);
    check("R5 register B", 32'(bFromImm), 32'd0);
    // R4: top of the 11-bit range
    drive({3'd7, 3'd5, 3'd3, 32'h0000_07FF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000});
    @(negedge clk);
    check("R4 max aAddr", aAddr, 32'h0000_3FF8);
    check("R7 max cAddr", cAddr, 32'h0000_3FF8);
    inValid = 1'b0;

    // R1: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset aAddr", aAddr, 32'd0);
    check("R1 re-reset outValid", 32'(outValid), 32'd0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule